// File: doc/BRIEF.md
# Segment Translation Front End

This block is the first stage of paged address translation. It keeps sixteen segment registers, indexed by the top four bits of the effective address. For each accepted request it reads the selected register and derives four things: the access key, the no-execute flag, the direct-store flag and the virtual segment identifier. It then produces a primary and a secondary hash and the tag that is later compared against page-table entries. A fetch from a segment where execution is not allowed is flagged as a fault.

Requests arrive on a valid/ready stream, and decoded results leave on a second valid/ready stream one cycle after they are accepted. A request is accepted when `req_valid` and `req_ready` are both high, and `req_ready` is high whenever the output register is empty or is being drained in that cycle. A result stays unchanged on the output for as long as `rsp_valid` is high and `rsp_ready` is low.

While a result is presented, the downstream lookup can pulse `miss_strobe` to report a lookup miss. The block then captures the context a software miss handler needs: the faulting address, the compare word, the error code, and the two page-group pointers computed from the table base and mask. It can also pulse `perm_strobe` to record a data permission fault in `perm_status`.

Top module: `seg_xlt_top`

## Requirements
- R1: During reset, `rsp_valid` and every captured register (`miss_ea`, `miss_cmp`, `miss_err`, `miss_pteg1`, `miss_pteg2`, `perm_status`) read zero.
- R2: `seg_we` writes `seg_wdata` into segment register `seg_wsel` at the clock edge. A request accepted in that same cycle still sees the old contents, and requests accepted later see the new value.
- R3: `rsp_key` is 1 when segment bit 29 is set and `req_user` is 1, or when segment bit 30 is set and `req_user` is 0. Otherwise it is 0.
- R4: The segment is selected by `req_ea[31:28]`. From it, `rsp_ds` is bit 31, `rsp_nx` is bit 28 and `rsp_vsid` is bits 23:0.
- R5: With page index P = `req_ea[27:12]`, `rsp_hash1` = vsid XOR P (24 bits), and `rsp_hash2` is the bitwise complement of `rsp_hash1`.
- R6: `rsp_tag` = (vsid << 7) | (P >> 10), 32 bits wide.
- R7: `rsp_xfault` is 1 only for a fetch (`req_kind` = 2) whose segment has bit 28 or bit 31 set.
- R8: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request shows up on the `rsp_*` outputs at the next edge. When there is no new acceptance, `rsp_ready` clears `rsp_valid`. A stalled result is held unchanged.
- R9: `miss_strobe` while `rsp_valid` is high loads `miss_ea` with `rsp_ea` and loads `miss_cmp` with 0x80000000 | `rsp_tag`.
- R10: On that same miss, `miss_err` gets bit 18 set for a fetch, bit 16 set for a store (`req_kind` = 1) and bit 19 equal to the key. All other bits are 0. Kind 0 and kind 3 are loads.
- R11: On that same miss, `miss_ptegN` = `tbl_base` | ((zero-extended `rsp_hashN` & `tbl_mask`) << 6), for N = 1 and N = 2.
- R12: `perm_strobe` while `rsp_valid` is high, for a non-fetch result, loads `perm_status` with 0x0A000000 for a store and 0x08000000 for a load. For a fetch result it has no effect.
- R13: `miss_strobe` and `perm_strobe` have no effect while `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 4 | Segment register index |
| seg_wdata | input | 32 | Segment register write data |
| tbl_base | input | 32 | Page table base address |
| tbl_mask | input | 32 | Page table hash mask |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| req_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result ready |
| rsp_ea | output | 32 | Effective address of the result |
| rsp_key | output | 1 | Access key |
| rsp_nx | output | 1 | No-execute flag |
| rsp_ds | output | 1 | Direct-store flag |
| rsp_vsid | output | 24 | Virtual segment identifier |
| rsp_hash1 | output | 24 | Primary hash |
| rsp_hash2 | output | 24 | Secondary hash |
| rsp_tag | output | 32 | Entry compare tag |
| rsp_xfault | output | 1 | Fetch no-execute fault |
| miss_strobe | input | 1 | Lookup miss for the presented result |
| perm_strobe | input | 1 | Data permission fault for the presented result |
| miss_ea | output | 32 | Captured miss address |
| miss_cmp | output | 32 | Captured compare word |
| miss_err | output | 32 | Captured error code |
| miss_pteg1 | output | 32 | Primary page-group address |
| miss_pteg2 | output | 32 | Secondary page-group address |
| perm_status | output | 32 | Captured permission fault status |

## Verification
Segment contents are random, so every combination of the direct-store, key and no-execute bits is exercised. These are crossed with all four access kinds and both privilege modes, which separates the key polarity and the two causes of a fetch fault. The write index is often steered to the segment the request in the same cycle reads, so the bench can tell write-after-read ordering apart from a bypass. Back-pressure on `rsp_ready` and strobes that arrive while no result is held show whether stalled results stay put and whether unqualified strobes are dropped. Random table masks show whether the mask is applied before the shift.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int ADDR_W  = 32;
  localparam int VSID_W  = 24;
  localparam int PG_W    = 16;
  localparam int PG_LSB  = 12;
  localparam int SEG_LSB = 28;
  localparam int TAG_SH  = 7;
  localparam int API_SH  = 10;

  localparam int B_DS    = 31;
  localparam int B_KSUP  = 30;
  localparam int B_KUSR  = 29;
  localparam int B_NX    = 28;

  localparam int E_FETCH = 18;
  localparam int E_STORE = 16;
  localparam int E_KEY   = 19;

  localparam logic [ADDR_W-1:0] CMP_VALID  = 32'h8000_0000;
  localparam logic [ADDR_W-1:0] FS_STORE   = 32'h0A00_0000;
  localparam logic [ADDR_W-1:0] FS_LOAD    = 32'h0800_0000;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_LOAD2 = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic              key;
    logic              nx;
    logic              ds;
    logic [VSID_W-1:0] vsid;
    logic [VSID_W-1:0] h1;
    logic [VSID_W-1:0] h2;
    logic [ADDR_W-1:0] tag;
    logic              xfault;
  } seg_dec_t;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int NSEG = 16,
  parameter int SW   = 32,
  localparam int SEL_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [SW-1:0]    wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [SW-1:0]    rdata
);
  logic [SW-1:0] bank [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic [SW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (we && (wsel == SEL_W'(g)))
        q <= wdata;
    end
    assign bank[g] = q;
  end

  assign rdata = bank[rsel];
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import xlt_pkg::*;
(
  input  logic [ADDR_W-1:0] sr,
  input  logic [ADDR_W-1:0] ea,
  input  logic [1:0]        kind,
  input  logic              user,
  output seg_dec_t          dec
);
  logic [PG_W-1:0]   pg;
  logic [VSID_W-1:0] vsid;
  logic [VSID_W-1:0] hsh;
  logic              is_fetch;

  always_comb begin
    pg       = ea[PG_LSB +: PG_W];
    vsid     = sr[VSID_W-1:0];
    hsh      = vsid ^ VSID_W'(pg);
    is_fetch = (kind == ACC_FETCH);

    dec.key    = (sr[B_KUSR] & user) | (sr[B_KSUP] & ~user);
    dec.nx     = sr[B_NX];
    dec.ds     = sr[B_DS];
    dec.vsid   = vsid;
    dec.h1     = hsh;
    dec.h2     = ~hsh;
    dec.tag    = (ADDR_W'(vsid) << TAG_SH) | ADDR_W'(pg >> API_SH);
    dec.xfault = is_fetch & (sr[B_NX] | sr[B_DS]);
  end
endmodule

// File: rtl/miss_ctx.sv
module miss_ctx
  import xlt_pkg::*;
#(
  parameter int GRP_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_strobe,
  input  logic              perm_strobe,
  input  logic              cur_valid,
  input  logic [ADDR_W-1:0] cur_ea,
  input  logic [1:0]        cur_kind,
  input  logic              cur_key,
  input  logic [ADDR_W-1:0] cur_tag,
  input  logic [VSID_W-1:0] cur_h1,
  input  logic [VSID_W-1:0] cur_h2,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_mask,
  output logic [ADDR_W-1:0] miss_ea,
  output logic [ADDR_W-1:0] miss_cmp,
  output logic [ADDR_W-1:0] miss_err,
  output logic [ADDR_W-1:0] miss_pteg1,
  output logic [ADDR_W-1:0] miss_pteg2,
  output logic [ADDR_W-1:0] perm_status
);
  logic              take_miss, take_perm;
  logic              is_fetch, is_store;
  logic [ADDR_W-1:0] err_n, grp1, grp2;

  function automatic logic [ADDR_W-1:0] grp_addr(
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] mask,
    input logic [VSID_W-1:0] h
  );
    return base | ((ADDR_W'(h) & mask) << GRP_SHIFT);
  endfunction

  always_comb begin
    is_fetch  = (cur_kind == ACC_FETCH);
    is_store  = (cur_kind == ACC_STORE);
    take_miss = miss_strobe & cur_valid;
    take_perm = perm_strobe & cur_valid & ~is_fetch;
    err_n     = (ADDR_W'(is_fetch) << E_FETCH)
              | (ADDR_W'(is_store) << E_STORE)
              | (ADDR_W'(cur_key)  << E_KEY);
    grp1      = grp_addr(tbl_base, tbl_mask, cur_h1);
    grp2      = grp_addr(tbl_base, tbl_mask, cur_h2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_ea    <= '0;
      miss_cmp   <= '0;
      miss_err   <= '0;
      miss_pteg1 <= '0;
      miss_pteg2 <= '0;
    end else if (take_miss) begin
      miss_ea    <= cur_ea;
      miss_cmp   <= CMP_VALID | cur_tag;
      miss_err   <= err_n;
      miss_pteg1 <= grp1;
      miss_pteg2 <= grp2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      perm_status <= '0;
    else if (take_perm)
      perm_status <= is_store ? FS_STORE : FS_LOAD;
  end

  // R9
  cmp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_strobe && cur_valid) |=> miss_cmp[ADDR_W-1]);

  // R10
  err_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss_err[E_FETCH], miss_err[E_STORE]}));

  // R12
  fstat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_status == '0) || (perm_status == FS_STORE) || (perm_status == FS_LOAD));

  // R13
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_valid) |=> ($stable(miss_ea) && $stable(perm_status)));
endmodule

// File: rtl/seg_xlt_top.sv
module seg_xlt_top
  import xlt_pkg::*;
#(
  parameter int NSEG      = 16,
  parameter int GRP_SHIFT = 6,
  localparam int SEL_W    = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_we,
  input  logic [SEL_W-1:0]  seg_wsel,
  input  logic [ADDR_W-1:0] seg_wdata,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_mask,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_ea,
  output logic              rsp_key,
  output logic              rsp_nx,
  output logic              rsp_ds,
  output logic [VSID_W-1:0] rsp_vsid,
  output logic [VSID_W-1:0] rsp_hash1,
  output logic [VSID_W-1:0] rsp_hash2,
  output logic [ADDR_W-1:0] rsp_tag,
  output logic              rsp_xfault,
  input  logic              miss_strobe,
  input  logic              perm_strobe,
  output logic [ADDR_W-1:0] miss_ea,
  output logic [ADDR_W-1:0] miss_cmp,
  output logic [ADDR_W-1:0] miss_err,
  output logic [ADDR_W-1:0] miss_pteg1,
  output logic [ADDR_W-1:0] miss_pteg2,
  output logic [ADDR_W-1:0] perm_status
);
  logic [ADDR_W-1:0] sr_rd;
  seg_dec_t          dec_c, dec_q;
  logic [ADDR_W-1:0] ea_q;
  logic [1:0]        kind_q;
  logic              vld_q;
  logic              accept;

  seg_bank #(.NSEG(NSEG), .SW(ADDR_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (seg_we),
    .wsel  (seg_wsel),
    .wdata (seg_wdata),
    .rsel  (req_ea[SEG_LSB +: SEL_W]),
    .rdata (sr_rd)
  );

  seg_decode u_dec (
    .sr   (sr_rd),
    .ea   (req_ea),
    .kind (req_kind),
    .user (req_user),
    .dec  (dec_c)
  );

  assign req_ready = ~vld_q | rsp_ready;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      dec_q  <= '0;
      ea_q   <= '0;
      kind_q <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      dec_q  <= dec_c;
      ea_q   <= req_ea;
      kind_q <= req_kind;
    end else if (rsp_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_ea     = ea_q;
  assign rsp_key    = dec_q.key;
  assign rsp_nx     = dec_q.nx;
  assign rsp_ds     = dec_q.ds;
  assign rsp_vsid   = dec_q.vsid;
  assign rsp_hash1  = dec_q.h1;
  assign rsp_hash2  = dec_q.h2;
  assign rsp_tag    = dec_q.tag;
  assign rsp_xfault = dec_q.xfault;

  miss_ctx #(.GRP_SHIFT(GRP_SHIFT)) u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_strobe (miss_strobe),
    .perm_strobe (perm_strobe),
    .cur_valid   (vld_q),
    .cur_ea      (ea_q),
    .cur_kind    (kind_q),
    .cur_key     (dec_q.key),
    .cur_tag     (dec_q.tag),
    .cur_h1      (dec_q.h1),
    .cur_h2      (dec_q.h2),
    .tbl_base    (tbl_base),
    .tbl_mask    (tbl_mask),
    .miss_ea     (miss_ea),
    .miss_cmp    (miss_cmp),
    .miss_err    (miss_err),
    .miss_pteg1  (miss_pteg1),
    .miss_pteg2  (miss_pteg2),
    .perm_status (perm_status)
  );

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ea) && $stable(rsp_tag)));

  // R8
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R5
  hash_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_hash1 ^ rsp_hash2) == '1));

  // R7
  xfault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_xfault |-> (rsp_nx || rsp_ds));
endmodule

// File: tb/seg_xlt_top_tb_top.sv
module seg_xlt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [3:0]  seg_wsel = '0;
  logic [31:0] seg_wdata = '0;
  logic [31:0] tbl_base = '0;
  logic [31:0] tbl_mask = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_ea;
  logic        rsp_key, rsp_nx, rsp_ds, rsp_xfault;
  logic [23:0] rsp_vsid, rsp_hash1, rsp_hash2;
  logic [31:0] rsp_tag;
  logic        miss_strobe = 1'b0;
  logic        perm_strobe = 1'b0;
  logic [31:0] miss_ea, miss_cmp, miss_err, miss_pteg1, miss_pteg2, perm_status;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  seg_xlt_top dut_i (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
    .seg_wdata(seg_wdata), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_kind(req_kind), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ea(rsp_ea), .rsp_key(rsp_key),
    .rsp_nx(rsp_nx), .rsp_ds(rsp_ds), .rsp_vsid(rsp_vsid),
    .rsp_hash1(rsp_hash1), .rsp_hash2(rsp_hash2), .rsp_tag(rsp_tag),
    .rsp_xfault(rsp_xfault), .miss_strobe(miss_strobe),
    .perm_strobe(perm_strobe), .miss_ea(miss_ea), .miss_cmp(miss_cmp),
    .miss_err(miss_err), .miss_pteg1(miss_pteg1), .miss_pteg2(miss_pteg2),
    .perm_status(perm_status)
  );

  // reference state
  logic [31:0] m_seg [16];
  logic        m_rv;
  logic [31:0] m_ea, m_tag;
  logic [1:0]  m_kind;
  logic        m_key, m_nx, m_ds, m_xf;
  logic [23:0] m_vsid, m_h1, m_h2;
  logic [31:0] m_mea, m_mcmp, m_err, m_p1, m_p2, m_fs;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] grp(input logic [31:0] b, input logic [31:0] m,
                                      input logic [23:0] h);
    logic [31:0] hz;
    hz = {8'h00, h};
    return b | ((hz & m) * 32'd64);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_seg[i] = '0;
    m_rv = 0; m_ea = 0; m_tag = 0; m_kind = 0; m_key = 0; m_nx = 0; m_ds = 0;
    m_xf = 0; m_vsid = 0; m_h1 = 0; m_h2 = 0;
    m_mea = 0; m_mcmp = 0; m_err = 0; m_p1 = 0; m_p2 = 0; m_fs = 0;
  endtask

  task automatic model_step();
    logic [31:0] sr;
    logic [15:0] pg;
    logic        acc;
    // strobes refer to the result held before this edge (R13 when m_rv low)
    if (miss_strobe && m_rv) begin
      m_mea  = m_ea;
      m_mcmp = 32'h8000_0000 | m_tag;
      m_err  = 0;
      if (m_kind == 2) m_err[18] = 1'b1;
      if (m_kind == 1) m_err[16] = 1'b1;
      m_err[19] = m_key;
      m_p1 = grp(tbl_base, tbl_mask, m_h1);
      m_p2 = grp(tbl_base, tbl_mask, m_h2);
    end
    if (perm_strobe && m_rv && m_kind != 2)
      m_fs = (m_kind == 1) ? 32'h0A00_0000 : 32'h0800_0000;
    acc = req_valid && (!m_rv || rsp_ready);
    if (acc) begin
      sr     = m_seg[req_ea[31:28]];
      pg     = req_ea[27:12];
      m_rv   = 1;
      m_ea   = req_ea;
      m_kind = req_kind;
      m_key  = req_user ? sr[29] : sr[30];
      m_nx   = sr[28];
      m_ds   = sr[31];
      m_vsid = sr[23:0];
      m_h1   = sr[23:0] ^ {8'h00, pg};
      m_h2   = ~m_h1;
      m_tag  = ({8'h00, sr[23:0]} * 32'd128) + {26'd0, pg[15:10]};
      m_xf   = (req_kind == 2) && (sr[28] || sr[31]);
    end else if (rsp_ready) begin
      m_rv = 0;
    end
    if (seg_we) m_seg[seg_wsel] = seg_wdata;   // R2: after the read above
  endtask

  task automatic compare_all();
    chk("R8 ready", {31'd0, req_ready}, {31'd0, !m_rv || rsp_ready});
    chk("R8 valid", {31'd0, rsp_valid}, {31'd0, m_rv});
    if (m_rv) begin
      chk("R8 ea", rsp_ea, m_ea);
      chk("R3 R2 key", {31'd0, rsp_key}, {31'd0, m_key});
      chk("R4 R2 flags", {29'd0, rsp_ds, rsp_nx, 1'b0}, {29'd0, m_ds, m_nx, 1'b0});
      chk("R4 R2 vsid", {8'd0, rsp_vsid}, {8'd0, m_vsid});
      chk("R5 hash1", {8'd0, rsp_hash1}, {8'd0, m_h1});
      chk("R5 hash2", {8'd0, rsp_hash2}, {8'd0, m_h2});
      chk("R6 tag", rsp_tag, m_tag);
      chk("R7 xfault", {31'd0, rsp_xfault}, {31'd0, m_xf});
    end
    chk("R9 R13 miss_ea", miss_ea, m_mea);
    chk("R9 miss_cmp", miss_cmp, m_mcmp);
    chk("R10 miss_err", miss_err, m_err);
    chk("R11 pteg1", miss_pteg1, m_p1);
    chk("R11 pteg2", miss_pteg2, m_p2);
    chk("R12 R13 perm_status", perm_status, m_fs);
  endtask

  task automatic drive(input int cyc);
    logic [31:0] w;
    w = $urandom;
    seg_we   = ($urandom_range(0, 3) == 0) || (cyc < 20);
    seg_wsel = (cyc < 20) ? 4'(cyc) : 4'($urandom);
    seg_wdata = $urandom;
    req_valid = (cyc >= 20) && ($urandom_range(0, 3) != 0);
    req_ea    = $urandom;
    if ($urandom_range(0, 2) == 0) req_ea[31:28] = seg_wsel;   // R2 same-cycle collision
    req_kind  = 2'($urandom);
    req_user  = w[0];
    rsp_ready = ($urandom_range(0, 3) != 0);
    miss_strobe = ($urandom_range(0, 4) == 0);
    perm_strobe = ($urandom_range(0, 4) == 0);
    tbl_base  = {w[31:16], 16'h0000};
    tbl_mask  = {$urandom} >> $urandom_range(0, 24);
  endtask

  initial begin
    model_reset();
    repeat (3) begin
      @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 valid", {31'd0, rsp_valid}, 32'd0);
      chk("R1 miss_cmp", miss_cmp, 32'd0);
      chk("R1 miss_err", miss_err, 32'd0);
      chk("R1 perm_status", perm_status, 32'd0);
      chk("R1 pteg", miss_pteg1 | miss_pteg2 | miss_ea, 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      drive(cyc);
      #1;
      compare_all();
      model_step();
      @(negedge clk);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule